// File: doc/BRIEF.md
# Sub-Pipelined On-the-Fly AES-128 Round-Key Generator

This block turns a 128-bit cipher key into the eleven AES-128 round keys (1408 bits in all) while the first data block is already moving through a sub-pipelined cipher. There is no separate pass that computes the keys ahead of time. Each round key takes `KX_STAGES` clock cycles, the same number of sub-stages that the cipher spends on one round. The cipher can therefore use round key i as soon as its slice of the pipeline needs it. Only eleven round-key registers exist. Each key is written into its own register once and then held there. A ready bit for each key tells the cipher which keys are present.

The S-box inversion, the affine map with the round constant, and the chained word XOR are spread over the `KX_STAGES` sub-stages (1, 3 or 5), with a register between sub-stages. Round key 0 is the loaded key itself. The recurrence uses a rotated and substituted last word, XORed with a round constant that doubles in GF(2^8) from 01 and then wraps to 1B and 36.

A second key can be written ahead of time into a standby register. It replaces the active key only when a frame-boundary strobe arrives, so both ends of a link can change keys on the same frame.

Top module: `otf_key_expander`

## Requirements
- R1: On the clock edge that samples `key_load`=1, slice 0 of `round_keys` (bits 127:0) takes `key_in` and `key_ready` becomes 11'b000_0000_0001. Every higher ready bit is cleared.
- R2: Round key i (bits 128*i+127 : 128*i) follows the AES-128 schedule. Its word 0 is the bits 127:96 of the previous key, XORed with SubWord(RotWord(previous bits 31:0)) and with Rcon placed in the top byte. Words 1..3 are a chained XOR. Rcon runs 01,02,04,08,10,20,40,80,1B,36.
- R3: Count the edge that samples a key start as edge 1. Bit i of `key_ready` is 1 after edge 1+i*`KX_STAGES` and 0 before it.
- R4: Ready bits fill strictly from bit 0 upward. All eleven are set after edge 10*`KX_STAGES`+1.
- R5: A `key_load` during an expansion abandons it and restarts from the new key, as in R1 and R3.
- R6: When no new start occurs, a round key whose ready bit is set keeps its value.
- R7: `shadow_load` stores `shadow_key` as pending and leaves the active keys and ready bits unchanged. A later `frame_sync` with a key pending starts expansion of that key, as in R1 and R3, and clears the pending state.
- R8: A `frame_sync` with no pending key changes neither the round keys nor the ready bits.
- R9: When `key_load` and `frame_sync` fall in the same cycle, `key_in` is used and the pending standby key stays pending for the next `frame_sync`.
- R10: When `shadow_load` and `frame_sync` fall in the same cycle, the swap uses the standby key stored earlier. The newly presented `shadow_key` becomes the next pending key.
- R11: After reset, `key_ready` is 0 and `round_keys` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_load | input | 1 | Start expansion of `key_in` at once |
| key_in | input | 128 | Key for an immediate start |
| shadow_load | input | 1 | Store `shadow_key` as the pending standby key |
| shadow_key | input | 128 | Standby key value |
| frame_sync | input | 1 | Frame boundary; swaps in the pending standby key |
| round_keys | output | 1408 | Round key i in bits 128*i+127 : 128*i |
| key_ready | output | 11 | Bit i set once round key i is written |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is an immediate key load and a frame-boundary swap. The second pair is a standby-key write and a frame-boundary swap. The bench drives each pair in one cycle. It checks that slice 0 right after that edge holds the winning key. It then issues one more frame strobe alone and checks which standby key starts. The full round-key-10 value confirms that the entire expansion ran on the correct key.

// File: rtl/aes_kx_pkg.sv
package aes_kx_pkg;

    localparam int KX_ROUNDS = 10;
    localparam int KX_KEYS   = KX_ROUNDS + 1;
    localparam int KX_KW     = 128;

    typedef logic [KX_KW-1:0] rkey_t;
    typedef logic [31:0]      kword_t;
    typedef logic [7:0]       gbyte_t;

    // primitive steps a sub-stage may perform, applied in field order
    typedef struct packed {
        logic to15;    // x -> x^15
        logic to63;    // x^15 -> x^63
        logic to254;   // x^63 -> x^254 (field inverse)
        logic affine;  // affine map + round constant
        logic chain;   // chained word XOR, key complete
    } step_mask_t;

    function automatic gbyte_t gf_xtime(input gbyte_t b);
        return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic gbyte_t gf_mul(input gbyte_t a, input gbyte_t b);
        gbyte_t p;
        gbyte_t aa;
        p  = '0;
        aa = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p = p ^ aa;
            aa = gf_xtime(aa);
        end
        return p;
    endfunction

    function automatic gbyte_t pow15(input gbyte_t x);
        gbyte_t t;
        t = gf_mul(gf_mul(x, x), x);          // x^3
        t = gf_mul(gf_mul(t, t), x);          // x^7
        return gf_mul(gf_mul(t, t), x);       // x^15
    endfunction

    function automatic gbyte_t pow63(input gbyte_t a15, input gbyte_t x);
        gbyte_t t;
        t = gf_mul(gf_mul(a15, a15), x);      // x^31
        return gf_mul(gf_mul(t, t), x);       // x^63
    endfunction

    function automatic gbyte_t pow254(input gbyte_t a63, input gbyte_t x);
        gbyte_t t;
        t = gf_mul(gf_mul(a63, a63), x);      // x^127
        return gf_mul(t, t);                  // x^254
    endfunction

    function automatic gbyte_t sb_affine(input gbyte_t b);
        return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]}
                 ^ {b[3:0], b[7:4]} ^ 8'h63;
    endfunction

    function automatic kword_t rot_word(input kword_t w);
        return {w[23:0], w[31:24]};
    endfunction

    // which primitive steps run in sub-stage p for a given stage count
    function automatic step_mask_t stage_mask(input int stages, input int p);
        step_mask_t m;
        m = '0;
        if (stages == 1) begin
            m = '1;
        end else if (stages == 3) begin
            case (p)
                0:       begin m.to15 = 1'b1; m.to63 = 1'b1; m.to254 = 1'b1; end
                1:       m.affine = 1'b1;
                default: m.chain = 1'b1;
            endcase
        end else begin
            case (p)
                0:       m.to15   = 1'b1;
                1:       m.to63   = 1'b1;
                2:       m.to254  = 1'b1;
                3:       m.affine = 1'b1;
                default: m.chain  = 1'b1;
            endcase
        end
        return m;
    endfunction

endpackage

// File: rtl/kx_step.sv
module kx_step
    import aes_kx_pkg::*;
(
    input  rkey_t      work_key,
    input  kword_t     mid_in,
    input  gbyte_t     rcon,
    input  step_mask_t mask,
    output kword_t     mid_out,
    output rkey_t      key_out
);
    kword_t src;
    kword_t sub;
    kword_t w4, w5, w6, w7;

    assign src = rot_word(work_key[31:0]);

    for (genvar b = 0; b < 4; b++) begin : g_byte
        gbyte_t x, v0, v1, v2, v3;
        always_comb begin
            x  = src[8*b +: 8];
            v0 = mask.to15   ? pow15(x)      : mid_in[8*b +: 8];
            v1 = mask.to63   ? pow63(v0, x)  : v0;
            v2 = mask.to254  ? pow254(v1, x) : v1;
            v3 = mask.affine ? sb_affine(v2) : v2;
        end
        if (b == 3) begin : g_top
            assign sub[31:24] = v3 ^ (mask.affine ? rcon : 8'h00);
        end else begin : g_low
            assign sub[8*b +: 8] = v3;
        end
    end

    assign w4 = work_key[127:96] ^ sub;
    assign w5 = work_key[95:64]  ^ w4;
    assign w6 = work_key[63:32]  ^ w5;
    assign w7 = work_key[31:0]   ^ w6;

    assign mid_out = sub;
    assign key_out = {w4, w5, w6, w7};
endmodule

// File: rtl/kx_ctrl.sv
module kx_ctrl
    import aes_kx_pkg::*;
#(
    parameter int STAGES = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    output logic       running,
    output logic       write_en,
    output logic [3:0] round_idx,
    output gbyte_t     rcon,
    output step_mask_t mask
);
    localparam int PW = (STAGES > 1) ? $clog2(STAGES) : 1;
    localparam logic [PW-1:0] LAST = PW'(STAGES - 1);

    logic [PW-1:0] phase_q;
    logic          last_phase;

    assign last_phase = (phase_q == LAST);
    assign write_en   = running && last_phase && !start;
    assign mask       = stage_mask(STAGES, int'(phase_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            running   <= 1'b0;
            phase_q   <= '0;
            round_idx <= 4'd1;
            rcon      <= 8'h01;
        end else if (start) begin
            running   <= 1'b1;
            phase_q   <= '0;
            round_idx <= 4'd1;
            rcon      <= 8'h01;
        end else if (running) begin
            if (last_phase) begin
                phase_q   <= '0;
                rcon      <= gf_xtime(rcon);
                round_idx <= round_idx + 4'd1;
                if (round_idx == 4'(KX_ROUNDS)) running <= 1'b0;
            end else begin
                phase_q <= phase_q + PW'(1);
            end
        end
    end
endmodule

// File: rtl/kx_shadow_bank.sv
module kx_shadow_bank
    import aes_kx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  key_load,
    input  rkey_t key_in,
    input  logic  shadow_load,
    input  rkey_t shadow_key,
    input  logic  frame_sync,
    output logic  start,
    output rkey_t start_key,
    output logic  pending
);
    rkey_t standby_q;
    logic  swap;

    assign swap      = frame_sync && pending && !key_load;
    assign start     = key_load || swap;
    assign start_key = key_load ? key_in : standby_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            standby_q <= '0;
            pending   <= 1'b0;
        end else begin
            if (shadow_load) begin
                standby_q <= shadow_key;
                pending   <= 1'b1;
            end else if (swap) begin
                pending   <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/otf_key_expander.sv
module otf_key_expander
    import aes_kx_pkg::*;
#(
    parameter int KX_STAGES = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     key_load,
    input  logic [127:0]             key_in,
    input  logic                     shadow_load,
    input  logic [127:0]             shadow_key,
    input  logic                     frame_sync,
    output logic [KX_KEYS*KX_KW-1:0] round_keys,
    output logic [KX_KEYS-1:0]       key_ready
);
    logic       start;
    rkey_t      start_key;
    logic       shadow_pending;
    logic       running;
    logic       write_en;
    logic [3:0] round_idx;
    gbyte_t     rcon;
    step_mask_t mask;
    rkey_t      work_q;
    kword_t     mid_q;
    kword_t     mid_next;
    rkey_t      key_next;

    rkey_t rk_q    [KX_KEYS];
    logic  ready_q [KX_KEYS];

    kx_shadow_bank u_bank (
        .clk         (clk),
        .rst         (rst),
        .key_load    (key_load),
        .key_in      (key_in),
        .shadow_load (shadow_load),
        .shadow_key  (shadow_key),
        .frame_sync  (frame_sync),
        .start       (start),
        .start_key   (start_key),
        .pending     (shadow_pending)
    );

    kx_ctrl #(.STAGES(KX_STAGES)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .running   (running),
        .write_en  (write_en),
        .round_idx (round_idx),
        .rcon      (rcon),
        .mask      (mask)
    );

    kx_step u_step (
        .work_key (work_q),
        .mid_in   (mid_q),
        .rcon     (rcon),
        .mask     (mask),
        .mid_out  (mid_next),
        .key_out  (key_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            work_q <= '0;
            mid_q  <= '0;
        end else if (start) begin
            work_q <= start_key;
            mid_q  <= '0;
        end else if (running) begin
            mid_q <= mid_next;
            if (write_en) work_q <= key_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rk_q[0]    <= '0;
            ready_q[0] <= 1'b0;
        end else if (start) begin
            rk_q[0]    <= start_key;
            ready_q[0] <= 1'b1;
        end
    end

    for (genvar i = 1; i < KX_KEYS; i++) begin : g_rk
        always_ff @(posedge clk) begin
            if (rst) begin
                rk_q[i]    <= '0;
                ready_q[i] <= 1'b0;
            end else if (start) begin
                ready_q[i] <= 1'b0;
            end else if (write_en && round_idx == 4'(i)) begin
                rk_q[i]    <= key_next;
                ready_q[i] <= 1'b1;
            end
        end
    end

    for (genvar i = 0; i < KX_KEYS; i++) begin : g_out
        assign round_keys[KX_KW*i +: KX_KW] = rk_q[i];
        assign key_ready[i]                 = ready_q[i];
    end
endmodule

// File: rtl/kx_checker.sv
module kx_checker
    import aes_kx_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     key_load,
    input logic [127:0]             key_in,
    input logic                     frame_sync,
    input logic                     shadow_pending,
    input logic [KX_KEYS*KX_KW-1:0] round_keys,
    input logic [KX_KEYS-1:0]       key_ready
);
    logic start_seen;
    assign start_seen = key_load || (frame_sync && shadow_pending);

    AST_LOAD_RK0: assert property (@(posedge clk) disable iff (rst)
        key_load |=> (round_keys[127:0] == $past(key_in)) && (key_ready == 11'h001)); // R1

    AST_READY_ORDER: assert property (@(posedge clk) disable iff (rst)
        ((key_ready + 11'd1) & key_ready) == 11'd0); // R4

    AST_READY_KEEP: assert property (@(posedge clk) disable iff (rst)
        !start_seen |=> ((key_ready & $past(key_ready)) == $past(key_ready))); // R6

    AST_IDLE_SYNC: assert property (@(posedge clk) disable iff (rst)
        (frame_sync && !shadow_pending && !key_load) |=> $stable(round_keys[127:0])); // R8

    for (genvar i = 1; i < KX_KEYS; i++) begin : g_hold
        AST_RK_HOLD: assert property (@(posedge clk) disable iff (rst)
            (key_ready[i] && !start_seen) |=>
                (round_keys[KX_KW*i +: KX_KW] == $past(round_keys[KX_KW*i +: KX_KW]))); // R6
    end
endmodule

bind otf_key_expander kx_checker u_kx_checker (
    .clk            (clk),
    .rst            (rst),
    .key_load       (key_load),
    .key_in         (key_in),
    .frame_sync     (frame_sync),
    .shadow_pending (shadow_pending),
    .round_keys     (round_keys),
    .key_ready      (key_ready)
);

// File: tb/otf_key_expander_tb.sv
module otf_key_expander_tb;
    localparam int STAGES = 3;
    localparam int NK     = 11;
    localparam int FULL   = 10 * STAGES + 1;

    // {key, round key 1, round key 10}
    localparam logic [383:0] VEC [3] = '{
        {128'h00000000000000000000000000000000,
         128'h62636363626363636263636362636363,
         128'hb4ef5bcb3e92e21123e951cf6f8f188e},
        {128'h000102030405060708090a0b0c0d0e0f,
         128'hd6aa74fdd2af72fadaa678f1d6ab76fe,
         128'h13111d7fe3944a17f307a78b4d2b30c5},
        {128'h2b7e151628aed2a6abf7158809cf4f3c,
         128'ha0fafe1788542cb123a339392a6c7605,
         128'hd014f9a8c9ee2589e13f0cc8b6630ca6}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              key_load = 1'b0;
    logic [127:0]      key_in = '0;
    logic              shadow_load = 1'b0;
    logic [127:0]      shadow_key = '0;
    logic              frame_sync = 1'b0;
    logic [NK*128-1:0] round_keys;
    logic [NK-1:0]     key_ready;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #2 clk = ~clk;

    otf_key_expander #(.KX_STAGES(STAGES)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .key_load    (key_load),
        .key_in      (key_in),
        .shadow_load (shadow_load),
        .shadow_key  (shadow_key),
        .frame_sync  (frame_sync),
        .round_keys  (round_keys),
        .key_ready   (key_ready)
    );

    function automatic logic [127:0] rk(input int i);
        return round_keys[128*i +: 128];
    endfunction

    function automatic logic [NK-1:0] exp_ready(input int k);
        logic [NK-1:0] m;
        for (int i = 0; i < NK; i++) m[i] = (k >= 1 + i * STAGES);
        return m;
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic load(input logic [127:0] k);
        key_load = 1'b1;
        key_in   = k;
        tick();
        key_load = 1'b0;
    endtask

    task automatic run_out(input int edges);
        for (int e = 0; e < edges; e++) tick();
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        run_out(3);
        rst = 1'b0;
        #1;
        // R11 reset state
        chk("R11 ready", 128'(key_ready), 128'd0);
        chk("R11 keys", rk(0) | rk(5) | rk(10), 128'd0);

        // vector table: R1, R2, R3, R4
        for (int v = 0; v < 3; v++) begin
            load(VEC[v][383:256]);
            chk("R1 rk0", rk(0), VEC[v][383:256]);
            chk("R3 ready", 128'(key_ready), 128'(exp_ready(1)));
            for (int k = 2; k <= FULL; k++) begin
                tick();
                if (v == 0) chk("R3 ready timing", 128'(key_ready), 128'(exp_ready(k)));
            end
            chk("R4 all ready", 128'(key_ready), 128'({NK{1'b1}}));
            chk("R2 rk1", rk(1), VEC[v][255:128]);
            chk("R2 rk10", rk(10), VEC[v][127:0]);
        end

        // R6 hold after completion
        run_out(5);
        chk("R6 rk10 hold", rk(10), VEC[2][127:0]);
        chk("R6 ready hold", 128'(key_ready), 128'({NK{1'b1}}));

        // R5 restart mid-expansion
        load(VEC[0][383:256]);
        run_out(5);
        load(VEC[1][383:256]);
        chk("R5 restart ready", 128'(key_ready), 128'(exp_ready(1)));
        run_out(FULL - 1);
        chk("R5 rk10", rk(10), VEC[1][127:0]);
        chk("R5 rk1", rk(1), VEC[1][255:128]);

        // R7 standby write does not disturb, swap on frame_sync
        shadow_load = 1'b1; shadow_key = VEC[2][383:256];
        tick();
        shadow_load = 1'b0;
        run_out(3);
        chk("R7 rk0 unchanged", rk(0), VEC[1][383:256]);
        chk("R7 ready unchanged", 128'(key_ready), 128'({NK{1'b1}}));
        frame_sync = 1'b1;
        tick();
        frame_sync = 1'b0;
        chk("R7 swap rk0", rk(0), VEC[2][383:256]);
        chk("R7 swap ready", 128'(key_ready), 128'(exp_ready(1)));
        run_out(FULL - 1);
        chk("R7 swap rk10", rk(10), VEC[2][127:0]);

        // R8 frame_sync with nothing pending
        frame_sync = 1'b1;
        tick();
        frame_sync = 1'b0;
        chk("R8 rk0", rk(0), VEC[2][383:256]);
        chk("R8 ready", 128'(key_ready), 128'({NK{1'b1}}));

        // R9 key_load and frame_sync together
        shadow_load = 1'b1; shadow_key = VEC[0][383:256];
        tick();
        shadow_load = 1'b0;
        key_load = 1'b1; key_in = VEC[1][383:256]; frame_sync = 1'b1;
        tick();
        key_load = 1'b0; frame_sync = 1'b0;
        chk("R9 load wins", rk(0), VEC[1][383:256]);
        run_out(FULL - 1);
        chk("R9 rk10", rk(10), VEC[1][127:0]);
        frame_sync = 1'b1;
        tick();
        frame_sync = 1'b0;
        chk("R9 standby kept", rk(0), VEC[0][383:256]);
        run_out(FULL - 1);
        chk("R9 standby rk10", rk(10), VEC[0][127:0]);

        // R10 shadow_load and frame_sync together
        shadow_load = 1'b1; shadow_key = VEC[1][383:256];
        tick();
        shadow_key = VEC[2][383:256]; frame_sync = 1'b1;
        tick();
        shadow_load = 1'b0; frame_sync = 1'b0;
        chk("R10 old standby used", rk(0), VEC[1][383:256]);
        run_out(FULL - 1);
        chk("R10 rk10", rk(10), VEC[1][127:0]);
        frame_sync = 1'b1;
        tick();
        frame_sync = 1'b0;
        chk("R10 new standby pending", rk(0), VEC[2][383:256]);
        run_out(FULL - 1);
        chk("R10 new rk10", rk(10), VEC[2][127:0]);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule